// File: doc/BRIEF.md
# Issue-Stage Hazard Interlock and Operand Forwarding Control

This block sits at the issue stage of a single-issue, in-order integer pipeline. Each cycle it is offered one decoded instruction: its class, up to two source register numbers, a destination register number and a valid flag. It keeps a small per-register countdown of the producers still in flight. From that countdown it decides whether the offered instruction issues now or is held for a cycle. For every source it issues with, it also says where the operand comes from: the register file, the ALU result forwarding path, or the load result buffer.

Two parameters turn the ALU/shift forwarding path and the load forwarding path on or off independently. Build variants with and without forwarding can therefore be compared cycle for cycle. Store data is read at the end of the pipe, so a store can take an ALU result produced one cycle earlier without forwarding and without waiting. Four running counters report issued instructions, held (bubble) cycles, instructions that used the ALU forwarding path, and instructions that used the load buffer path.

Top module: `hazard_ctl`

## Requirements
- R1: After reset, all four counters read zero, no producer is pending, and the first valid instruction issues in the cycle it is offered.
- R2: Class encoding is 0 ALU, 1 shift, 2 load, 3 store. An ALU or shift result is usable at distance 1 (the next instruction) over the ALU forwarding path when ALU_BYP=1. When ALU_BYP=0 it is usable only at distance 2, from the register file.
- R3: A load result is usable at distance 2 over the load buffer path when LOAD_BYP=1; that is the cycle in which the load writes the register file. When LOAD_BYP=0 it is usable only at distance 3, from the register file. A load consumer at distance 1 always waits.
- R4: The data source of a store (src2) is read late. When the forwarding path for its producer's class is disabled, that source may issue one cycle before the normal latency and takes its value from the register file. An ALU producer at distance 1 therefore causes no wait even with ALU_BYP=0.
- R5: When several in-flight producers target the same register, the youngest one decides both the wait and the operand source.
- R6: Register 0 never creates a dependence, and a source of register 0 is always taken from the register file (code 0).
- R7: A waiting instruction gives stall=1 and issue=0. The bubble writes no register, the waiting instruction is re-evaluated the next cycle, and the stall counter increments once per bubble.
- R8: The issued counter increments once per issued instruction. The ALU-forwarding counter increments once per issued instruction with at least one source on code 1. The load-forwarding counter increments once per issued instruction with at least one source on code 2.
- R9: Source select codes are 0 register file, 1 ALU forwarding, 2 load buffer. Both selects read 0 whenever issue is 0, and the select codes match the latency rules above for arbitrary instruction streams in all four forwarding configurations.
- R10: A load ignores src2 for dependence and reports src2 code 0. A store writes no register, so a later reader of the store's rd field does not wait on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Offered instruction is valid |
| in_cls | input | 2 | Class: 0 ALU, 1 shift, 2 load, 3 store |
| in_rs1 | input | RW | First source (address source for loads and stores) |
| in_rs2 | input | RW | Second source (store data for stores) |
| in_rd | input | RW | Destination register |
| issue | output | 1 | Offered instruction issues this cycle |
| stall | output | 1 | Offered instruction is held; a bubble is inserted |
| src1_sel | output | 2 | Operand source for src1 |
| src2_sel | output | 2 | Operand source for src2 |
| cnt_issued | output | CW | Issued instruction count |
| cnt_alu_fwd | output | CW | Instructions that used ALU forwarding |
| cnt_load_fwd | output | CW | Instructions that used the load buffer path |
| cnt_stall | output | CW | Bubble cycles inserted |

## Verification
Issue, stall and both selects are combinational on the offered instruction and the scoreboard. They are due in the same cycle the instruction is driven, so the monitor compares them two time units after the falling edge on which the driver applied the inputs. The scoreboard effect of an issue shows up in the next cycle's decision. The reference model therefore counts distance as the number of rising edges since the producer issued. The counters are registered one edge after each decision; they are compared only after the stream has drained, against totals the driver accumulated from its own expectations.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int NREG     = 32,
  parameter int ALU_BYP  = 1,
  parameter int LOAD_BYP = 1,
  parameter int CW       = 16,
  localparam int RW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_cls,
  input  logic [RW-1:0] in_rs1,
  input  logic [RW-1:0] in_rs2,
  input  logic [RW-1:0] in_rd,
  output logic          issue,
  output logic          stall,
  output logic [1:0]    src1_sel,
  output logic [1:0]    src2_sel,
  output logic [CW-1:0] cnt_issued,
  output logic [CW-1:0] cnt_alu_fwd,
  output logic [CW-1:0] cnt_load_fwd,
  output logic [CW-1:0] cnt_stall
);

  localparam logic [1:0] C_STORE = 2'd3;
  localparam logic [1:0] C_LOAD  = 2'd2;
  localparam logic [1:0] LAT_ALU = 2'd2;
  localparam logic [1:0] LAT_LD  = 2'd3;

  logic [1:0] sb_cnt [NREG];
  logic       sb_ld  [NREG];

  // returns {wait, sel}
  function automatic logic [2:0] judge(input logic [1:0] c, input logic ld,
                                       input logic is_r0, input logic late);
    logic byp;
    byp = ld ? (LOAD_BYP != 0) : (ALU_BYP != 0);
    if (is_r0 || c == 2'd0)    return 3'b000;
    if (byp && c == 2'd1)      return {1'b0, ld ? 2'd2 : 2'd1};
    if (!byp && late && c == 2'd1) return 3'b000;
    return 3'b100;
  endfunction

  logic       use2, writes;
  logic [2:0] j1, j2;
  logic       hazard;

  assign use2   = in_cls != C_LOAD;
  assign writes = in_cls != C_STORE;
  assign j1     = judge(sb_cnt[in_rs1], sb_ld[in_rs1], in_rs1 == '0, 1'b0);
  assign j2     = judge(sb_cnt[in_rs2], sb_ld[in_rs2], in_rs2 == '0, in_cls == C_STORE);
  assign hazard = j1[2] | (use2 & j2[2]);
  assign issue  = in_valid & ~hazard;
  assign stall  = in_valid & hazard;
  assign src1_sel = issue ? j1[1:0] : 2'd0;
  assign src2_sel = (issue && use2) ? j2[1:0] : 2'd0;

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (!rst_n || r == 0) begin
        sb_cnt[r] <= 2'd0;
        sb_ld[r]  <= 1'b0;
      end else if (issue && writes && in_rd == RW'(r)) begin
        sb_cnt[r] <= (in_cls == C_LOAD) ? LAT_LD - 2'd1 : LAT_ALU - 2'd1;
        sb_ld[r]  <= in_cls == C_LOAD;
      end else if (sb_cnt[r] != 2'd0) begin
        sb_cnt[r] <= sb_cnt[r] - 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_issued   <= '0;
      cnt_alu_fwd  <= '0;
      cnt_load_fwd <= '0;
      cnt_stall    <= '0;
    end else begin
      if (issue) cnt_issued <= cnt_issued + 1'b1;
      if (stall) cnt_stall  <= cnt_stall + 1'b1;
      if (src1_sel == 2'd1 || src2_sel == 2'd1) cnt_alu_fwd  <= cnt_alu_fwd + 1'b1;
      if (src1_sel == 2'd2 || src2_sel == 2'd2) cnt_load_fwd <= cnt_load_fwd + 1'b1;
    end
  end

  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot({issue, stall}));
  assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !issue && !stall);
  assert_sel_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |-> src1_sel == 2'd0 && src2_sel == 2'd0);
  assert_zero_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && in_rs1 == '0) |-> src1_sel == 2'd0);
  assert_issue_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> cnt_issued == $past(cnt_issued) + 1'b1);
  assert_stall_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> cnt_stall == $past(cnt_stall) + 1'b1);
  assert_load_no_src2_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && in_cls == C_LOAD) |-> src2_sel == 2'd0);

  generate
    if (LOAD_BYP == 0) begin : g_nold
      assert_no_load_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        src1_sel != 2'd2 && src2_sel != 2'd2);
    end
    if (ALU_BYP == 0) begin : g_noalu
      assert_no_alu_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        src1_sel != 2'd1 && src2_sel != 2'd1);
    end
  endgenerate

endmodule

// File: tb/sim_hazard_ctl.sv
`timescale 1ns/1ps
module sim_hazard_ctl;
  localparam int NK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       v   [NK];
  logic [1:0] cl  [NK];
  logic [4:0] ra  [NK];
  logic [4:0] rb  [NK];
  logic [4:0] rd  [NK];
  logic       iss [NK];
  logic       stl [NK];
  logic [1:0] s1  [NK];
  logic [1:0] s2  [NK];
  logic [15:0] c_is [NK];
  logic [15:0] c_af [NK];
  logic [15:0] c_lf [NK];
  logic [15:0] c_st [NK];

  // k0: both paths, k1: load path only, k2: none, k3: ALU path only
  for (genvar g = 0; g < NK; g++) begin : g_dut
    hazard_ctl #(.NREG(32), .ALU_BYP((g == 0 || g == 3) ? 1 : 0),
                 .LOAD_BYP((g <= 1) ? 1 : 0), .CW(16)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(v[g]), .in_cls(cl[g]),
      .in_rs1(ra[g]), .in_rs2(rb[g]), .in_rd(rd[g]),
      .issue(iss[g]), .stall(stl[g]), .src1_sel(s1[g]), .src2_sel(s2[g]),
      .cnt_issued(c_is[g]), .cnt_alu_fwd(c_af[g]),
      .cnt_load_fwd(c_lf[g]), .cnt_stall(c_st[g]));
  end

  typedef struct {
    int k; bit iss; bit stl; logic [1:0] a; logic [1:0] b; string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  int cyc = 0;
  int last [NK][32];
  bit mld  [NK][32];
  int e_is [NK], e_af [NK], e_lf [NK], e_st [NK];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " issue"}, int'(iss[e.k]), int'(e.iss));
      chk({e.tag, " stall"}, int'(stl[e.k]), int'(e.stl));
      chk({e.tag, " src1_sel"}, int'(s1[e.k]), int'(e.a));
      chk({e.tag, " src2_sel"}, int'(s2[e.k]), int'(e.b));
    end
  end

  task automatic model_src(input int k, input int r, input bit late,
                           output bit blk, output logic [1:0] sel);
    int dd, lnb; bit byp;
    blk = 1'b0; sel = 2'd0;
    if (r == 0) return;
    dd  = cyc - last[k][r];
    lnb = mld[k][r] ? 3 : 2;
    byp = mld[k][r] ? (k <= 1) : (k == 0 || k == 3);
    if (dd >= lnb) return;
    if (byp && dd == lnb - 1) sel = mld[k][r] ? 2'd2 : 2'd1;
    else if (!byp && late && dd == lnb - 1) sel = 2'd0;
    else blk = 1'b1;
  endtask

  task automatic send(input int k, input logic [1:0] c, input int r1,
                      input int r2, input int d, input string tag);
    bit b1, b2, blk; logic [1:0] x1, x2; exp_t e;
    forever begin
      @(negedge clk);
      v[k] = 1'b1; cl[k] = c; ra[k] = 5'(r1); rb[k] = 5'(r2); rd[k] = 5'(d);
      model_src(k, r1, 1'b0, b1, x1);
      if (c == 2'd2) begin b2 = 1'b0; x2 = 2'd0; end
      else model_src(k, r2, c == 2'd3, b2, x2);
      blk = b1 | b2;
      e.k = k; e.iss = !blk; e.stl = blk; e.tag = tag;
      e.a = blk ? 2'd0 : x1; e.b = blk ? 2'd0 : x2;
      q.push_back(e);
      if (blk) e_st[k]++;
      else begin
        e_is[k]++;
        if (e.a == 2'd1 || e.b == 2'd1) e_af[k]++;
        if (e.a == 2'd2 || e.b == 2'd2) e_lf[k]++;
        if (c != 2'd3 && d != 0) begin last[k][d] = cyc; mld[k][d] = (c == 2'd2); end
        break;
      end
    end
  endtask

  task automatic idle(input int k, input int n);
    exp_t e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      v[k] = 1'b0;
      e.k = k; e.iss = 0; e.stl = 0; e.a = 0; e.b = 0; e.tag = "R7 idle";
      q.push_back(e);
    end
  endtask

  initial begin
    #3000000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < NK; k++) begin
      v[k] = 0; cl[k] = 0; ra[k] = 0; rb[k] = 0; rd[k] = 0;
      e_is[k] = 0; e_af[k] = 0; e_lf[k] = 0; e_st[k] = 0;
      for (int r = 0; r < 32; r++) begin last[k][r] = -100; mld[k][r] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NK; k++) begin
      chk("R1 reset issued", int'(c_is[k]), 0);
      chk("R1 reset stall cnt", int'(c_st[k]), 0);
      chk("R1 reset alu fwd", int'(c_af[k]), 0);
      chk("R1 reset load fwd", int'(c_lf[k]), 0);
    end
    for (int k = 0; k < NK; k++) begin
      send(k, 2'd0, 9, 10, 1, "R1 first issue");
      send(k, 2'd1, 1, 11, 2, "R2 alu consumer");
      idle(k, 3);
      send(k, 2'd2, 12, 0, 3, "R3 load");
      send(k, 2'd0, 3, 13, 4, "R3 load consumer");
      idle(k, 3);
      send(k, 2'd0, 14, 15, 5, "R4 alu to store");
      send(k, 2'd3, 16, 5, 0, "R4 store data");
      idle(k, 3);
      send(k, 2'd2, 17, 0, 6, "R3 load to store");
      send(k, 2'd3, 18, 6, 0, "R4 store data load");
      idle(k, 3);
      send(k, 2'd2, 19, 0, 7, "R5 old load");
      send(k, 2'd0, 20, 21, 7, "R5 young alu");
      send(k, 2'd0, 7, 22, 8, "R5 youngest wins");
      idle(k, 3);
      send(k, 2'd0, 23, 24, 0, "R6 write r0");
      send(k, 2'd0, 0, 0, 25, "R6 read r0");
      idle(k, 3);
      send(k, 2'd0, 26, 27, 28, "R10 alu");
      send(k, 2'd2, 29, 28, 30, "R10 load ignores src2");
      send(k, 2'd3, 1, 2, 31, "R10 store no dest");
      send(k, 2'd0, 31, 31, 9, "R10 after store");
      idle(k, 3);
      for (int i = 0; i < 300; i++)
        send(k, 2'($urandom_range(0, 3)), $urandom_range(0, 7),
             $urandom_range(0, 7), $urandom_range(0, 7), "R9 random");
      idle(k, 4);
    end
    idle(0, 2);
    for (int k = 0; k < NK; k++) begin
      chk("R8 issued count", int'(c_is[k]), e_is[k]);
      chk("R8 alu fwd count", int'(c_af[k]), e_af[k]);
      chk("R8 load fwd count", int'(c_lf[k]), e_lf[k]);
      chk("R7 stall count", int'(c_st[k]), e_st[k]);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule